// File: doc/BRIEF.md
# Four-Phase Clock Generator

This block derives the four clock phases needed by four-phase dynamic logic from a single fast input clock. At its core is a four-stage twisted ring (a Johnson counter): the complement of the last stage feeds the first stage, so the ring walks through eight states and then repeats. One full walk of eight states is one period of the generated system clock.

The ring does not have to advance on every input edge. A programmable down-counter sets the step rate. The ring advances once each time the counter reaches zero, and the counter then reloads from the rate setting. A small setting gives a fast ring, and a setting of zero steps the ring on every edge. Two long phases come from the last stage and its inverse. Two short precharge pulses are formed by gating a pair of stages, and each pulse opens its own long phase. A mode input selects which pair of stages is gated. In wide mode each pulse lasts two ring states. In narrow mode it lasts one. All four outputs are registered.

Ring states are written stage1..stage4, and they advance in this order: `RS_ZERO` (0000) to `RS_FILL1` (1000), `RS_FILL1` to `RS_FILL2` (1100), `RS_FILL2` to `RS_FILL3` (1110), `RS_FILL3` to `RS_FULL` (1111), `RS_FULL` to `RS_DRAIN1` (0111), `RS_DRAIN1` to `RS_DRAIN2` (0011), `RS_DRAIN2` to `RS_DRAIN3` (0001), and `RS_DRAIN3` back to `RS_ZERO`. Any illegal code returns to `RS_ZERO`. Each transition happens only on a divider step.

Top module: `fp_clkgen`

## Requirements
- R1: Reset (active low, asynchronous) clears every ring stage and the divider. While reset is held, the outputs are `ph_main_a`=0, `ph_main_b`=1, `ph_pre_a`=0, `ph_pre_b`=1. The first ring step happens on the first rising edge after reset is released.
- R2: Each step moves the ring one state along the eight-state order given above. `ph_main_a` is therefore high for four consecutive steps and then low for four.
- R3: Steps are `rate_sel`+1 input clocks apart, so a setting of 0 steps on every clock. A new `rate_sel` value takes effect when the divider next reloads, which happens at the step that ends the current interval.
- R4: `ph_main_a` equals stage4, and `ph_main_b` is its complement. Exactly one of the two is high at all times.
- R5: With `narrow_pre`=0, `ph_pre_a` = stage2 AND stage4 (high in `RS_FULL` and `RS_DRAIN1`), and `ph_pre_b` = NOT stage2 AND NOT stage4 (high in `RS_ZERO` and `RS_FILL1`).
- R6: With `narrow_pre`=1, `ph_pre_a` = stage1 AND stage4 (high in `RS_FULL` only), and `ph_pre_b` = NOT stage1 AND NOT stage4 (high in `RS_ZERO` only).
- R7: A precharge pulse is high only while its own long phase is high (`ph_pre_a` only with `ph_main_a`, `ph_pre_b` only with `ph_main_b`). Each pulse is high in the first state of its long phase.
- R8: The outputs are registered and change only on a ring step. A change of `narrow_pre` between steps appears at the next step and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | DIV_W | Divider reload value; steps are rate_sel+1 clocks apart |
| narrow_pre | input | 1 | 0: two-state precharge pulses, 1: one-state pulses |
| ph_main_a | output | 1 | Long phase, high while stage4 is set |
| ph_main_b | output | 1 | Long phase, high while stage4 is clear |
| ph_pre_a | output | 1 | Precharge pulse opening ph_main_a |
| ph_pre_b | output | 1 | Precharge pulse opening ph_main_b |

## Verification
A step takes effect at the same rising edge on which the divider is at zero. The ring state and all four registered phases update on that edge, so there is no extra cycle of latency. A new rate or mode value becomes visible only at the following reload or step. The bench keeps its own model of the divider count, the ring index and the mode latched at each step, and updates that model on rising edges. It compares the design outputs with the model at every falling edge, which is half a clock after any update. Reset values are sampled while reset is still held, including after an asynchronous reset that arrives mid-run.

// File: rtl/fp_clkgen_pkg.sv
package fp_clkgen_pkg;

    localparam int RING_STAGES = 4;
    localparam int RING_STATES = 2 * RING_STAGES;

    // stage1 is bit 3, stage4 (last stage) is bit 0
    typedef enum logic [RING_STAGES-1:0] {
        RS_ZERO   = 4'b0000,
        RS_FILL1  = 4'b1000,
        RS_FILL2  = 4'b1100,
        RS_FILL3  = 4'b1110,
        RS_FULL   = 4'b1111,
        RS_DRAIN1 = 4'b0111,
        RS_DRAIN2 = 4'b0011,
        RS_DRAIN3 = 4'b0001
    } ring_state_e;

    typedef enum logic {
        PRE_WIDE   = 1'b0,
        PRE_NARROW = 1'b1
    } pre_mode_e;

    typedef struct packed {
        logic main_a;
        logic main_b;
        logic pre_a;
        logic pre_b;
    } phase_set_t;

    localparam phase_set_t PHASE_RESET = '{main_a: 1'b0, main_b: 1'b1,
                                           pre_a: 1'b0, pre_b: 1'b1};

endpackage

// File: rtl/fp_rate_div.sv
module fp_rate_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] reload,
    output logic             step
);

    logic [DIV_W-1:0] count_q;

    assign step = (count_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (step) begin
            count_q <= reload;
        end else begin
            count_q <= count_q - 1'b1;
        end
    end

endmodule

// File: rtl/fp_ring.sv
module fp_ring
    import fp_clkgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    output ring_state_e state,
    output ring_state_e state_next
);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= RS_ZERO;
        end else if (step) begin
            state <= state_next;
        end
    end

    // twisted-ring successor
    always_comb begin
        unique case (state)
            RS_ZERO:   state_next = RS_FILL1;
            RS_FILL1:  state_next = RS_FILL2;
            RS_FILL2:  state_next = RS_FILL3;
            RS_FILL3:  state_next = RS_FULL;
            RS_FULL:   state_next = RS_DRAIN1;
            RS_DRAIN1: state_next = RS_DRAIN2;
            RS_DRAIN2: state_next = RS_DRAIN3;
            RS_DRAIN3: state_next = RS_ZERO;
            default:   state_next = RS_ZERO;
        endcase
    end

endmodule

// File: rtl/fp_phase_enc.sv
module fp_phase_enc
    import fp_clkgen_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        step,
    input  pre_mode_e   mode,
    input  ring_state_e state_next,
    output phase_set_t  phases
);

    logic       stg1, stg2, stg4;
    phase_set_t phases_d;

    assign stg1 = state_next[3];
    assign stg2 = state_next[2];
    assign stg4 = state_next[0];

    // output decode of the state being entered
    always_comb begin
        phases_d.main_a = stg4;
        phases_d.main_b = ~stg4;
        unique case (mode)
            PRE_WIDE: begin
                phases_d.pre_a = stg2 & stg4;
                phases_d.pre_b = ~stg2 & ~stg4;
            end
            PRE_NARROW: begin
                phases_d.pre_a = stg1 & stg4;
                phases_d.pre_b = ~stg1 & ~stg4;
            end
            default: begin
                phases_d.pre_a = 1'b0;
                phases_d.pre_b = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            phases <= PHASE_RESET;
        end else if (step) begin
            phases <= phases_d;
        end
    end

endmodule

// File: rtl/fp_clkgen.sv
module fp_clkgen
    import fp_clkgen_pkg::*;
#(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [DIV_W-1:0] rate_sel,
    input  logic             narrow_pre,
    output logic             ph_main_a,
    output logic             ph_main_b,
    output logic             ph_pre_a,
    output logic             ph_pre_b
);

    logic        ring_step;
    ring_state_e ring_state;
    ring_state_e ring_next;
    phase_set_t  phases;
    pre_mode_e   pre_mode;

    assign pre_mode = narrow_pre ? PRE_NARROW : PRE_WIDE;

    fp_rate_div #(.DIV_W(DIV_W)) u_div (
        .clk    (clk),
        .rst_n  (rst_n),
        .reload (rate_sel),
        .step   (ring_step)
    );

    fp_ring u_ring (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (ring_step),
        .state      (ring_state),
        .state_next (ring_next)
    );

    fp_phase_enc u_enc (
        .clk        (clk),
        .rst_n      (rst_n),
        .step       (ring_step),
        .mode       (pre_mode),
        .state_next (ring_next),
        .phases     (phases)
    );

    assign ph_main_a = phases.main_a;
    assign ph_main_b = phases.main_b;
    assign ph_pre_a  = phases.pre_a;
    assign ph_pre_b  = phases.pre_b;

endmodule

// File: rtl/fp_clkgen_chk.sv
module fp_clkgen_chk (
    input logic clk,
    input logic rst_n,
    input logic step,
    input logic ph_main_a,
    input logic ph_main_b,
    input logic ph_pre_a,
    input logic ph_pre_b
);

    // R4
    main_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_main_a != ph_main_b);

    // R7
    pre_a_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_pre_a |-> ph_main_a);

    // R7
    pre_b_inside_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ph_pre_b |-> ph_main_b);

    // R7
    pre_a_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_main_a) |-> ph_pre_a);

    // R7
    pre_b_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ph_main_b) |-> ph_pre_b);

    // R8
    hold_between_steps_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable({ph_main_a, ph_main_b, ph_pre_a, ph_pre_b}));

endmodule

bind fp_clkgen fp_clkgen_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step      (ring_step),
    .ph_main_a (ph_main_a),
    .ph_main_b (ph_main_b),
    .ph_pre_a  (ph_pre_a),
    .ph_pre_b  (ph_pre_b)
);

// File: tb/fp_clkgen_test.sv
module fp_clkgen_test;

    localparam int DIV_W = 8;

    typedef struct packed {
        logic [DIV_W-1:0] rate;
        logic             narrow;
        logic [7:0]       cycles;
    } vec_t;

    // R3 R5 R6: rate, mode, clocks to observe after reset
    localparam vec_t VECS [6] = '{
        '{8'd0, 1'b0, 8'd24},
        '{8'd0, 1'b1, 8'd24},
        '{8'd1, 1'b0, 8'd40},
        '{8'd2, 1'b1, 8'd50},
        '{8'd3, 1'b0, 8'd70},
        '{8'd5, 1'b1, 8'd100}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [DIV_W-1:0] rate_sel = '0;
    logic             narrow_pre = 1'b0;
    logic             ph_main_a, ph_main_b, ph_pre_a, ph_pre_b;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    fp_clkgen #(.DIV_W(DIV_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .rate_sel   (rate_sel),
        .narrow_pre (narrow_pre),
        .ph_main_a  (ph_main_a),
        .ph_main_b  (ph_main_b),
        .ph_pre_a   (ph_pre_a),
        .ph_pre_b   (ph_pre_b)
    );

    // reference model built from the requirements
    logic [2:0]       m_idx;
    logic [DIV_W-1:0] m_cnt;
    logic             m_narrow;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_idx    <= 3'd0;
            m_cnt    <= '0;
            m_narrow <= 1'b0;
        end else if (m_cnt == '0) begin
            m_idx    <= m_idx + 3'd1;
            m_cnt    <= rate_sel;
            m_narrow <= narrow_pre;
        end else begin
            m_cnt <= m_cnt - 1'b1;
        end
    end

    task automatic chk(input string req, input string name,
                       input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0b expected=%0b at %0t",
                     req, name, act, exp, $time);
        end
    endtask

    task automatic check_model(input string req);
        logic ea, epa, epb;
        ea  = (m_idx >= 3'd4);
        epa = m_narrow ? (m_idx == 3'd4) : (m_idx == 3'd4 || m_idx == 3'd5);
        epb = m_narrow ? (m_idx == 3'd0) : (m_idx <= 3'd1);
        chk({req, " R2"}, "ph_main_a", ph_main_a, ea);
        chk({req, " R4"}, "ph_main_b", ph_main_b, ~ea);
        chk({req, m_narrow ? " R6" : " R5"}, "ph_pre_a", ph_pre_a, epa);
        chk({req, m_narrow ? " R6" : " R5"}, "ph_pre_b", ph_pre_b, epb);
    endtask

    task automatic check_reset();
        chk("R1", "ph_main_a", ph_main_a, 1'b0);
        chk("R1", "ph_main_b", ph_main_b, 1'b1);
        chk("R1", "ph_pre_a",  ph_pre_a,  1'b0);
        chk("R1", "ph_pre_b",  ph_pre_b,  1'b1);
    endtask

    task automatic restart(input logic [DIV_W-1:0] r, input logic n);
        @(negedge clk);
        rst_n      = 1'b0;
        rate_sel   = r;
        narrow_pre = n;
        repeat (2) @(negedge clk);
        check_reset();
        rst_n = 1'b1;
    endtask

    initial begin
        foreach (VECS[i]) begin
            restart(VECS[i].rate, VECS[i].narrow);
            for (int c = 0; c < int'(VECS[i].cycles); c++) begin
                @(negedge clk);
                check_model("R3");
            end
        end

        // R3: rate change takes effect at the next reload
        restart(8'd4, 1'b0);
        for (int c = 0; c < 13; c++) begin
            @(negedge clk);
            check_model("R3");
        end
        rate_sel = 8'd0;
        for (int c = 0; c < 14; c++) begin
            @(negedge clk);
            check_model("R3");
        end

        // R8: mode change appears only at the next step
        rate_sel = 8'd6;
        for (int c = 0; c < 10; c++) begin
            @(negedge clk);
            check_model("R8");
        end
        narrow_pre = 1'b1;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            check_model("R8");
        end
        narrow_pre = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            check_model("R8");
        end

        // R1: asynchronous reset in the middle of a run
        @(negedge clk);
        #2 rst_n = 1'b0;
        #1 check_reset();
        @(negedge clk);
        check_reset();
        rst_n = 1'b1;
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            check_model("R1");
        end

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        #1_500_000;
        fails++;
        $display("FAIL watchdog expired: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule